// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the device side of a byte-wide command channel. A host writes a command one byte at a time into a single data port, watches a status byte to learn whether more bytes are wanted, starts execution with a go request and then drains the response through the same data port. Two further status bytes carry a 16-bit burst count, the number of bytes the host may move before it has to look at status again. A count of zero tells the host to wait.

The engine learns the command length from the header. Bytes 2 to 5 of every command hold the total length as a big-endian 32-bit value, and the header is 10 bytes long. An execution agent gets a request line, the decoded length and a read port into the command buffer. It returns its response as a stream of bytes. One buffer holds the command first and then the response. Writing the ready bit of the status register aborts whatever is in progress.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset the status byte (offset 0x18) reads 0xC0 (bit 7 valid, bit 6 ready). The burst count reads DEPTH, with its low byte at offset 0x19 and its high byte at offset 0x1A.
- R2: Burst count gives the bytes the host may move now. While receiving with the length still unknown it is DEPTH minus the bytes received. Once the length is known it is the length minus the bytes received. During the response phase it is the number of unread bytes. In every other case it is 0.
- R3: The expect bit (bit 3) reads 1 from the first accepted command byte until the final byte. Once the whole command is in, status reads 0x80.
- R4: The command length is the big-endian value in bytes 2 (most significant) to 5. It appears on `exec_len` during execution.
- R5: A decoded length below 10 or above DEPTH sets the error bit (bit 2) and clears expect, so status reads 0x84. Later data writes are ignored.
- R6: Data-port writes (offset 0x24) are accepted only in the ready state or while a command is still being received. At all other times they change neither status, burst count nor buffer contents.
- R7: A status write with bit 5 set starts execution only when a complete command is waiting. `exec_req` rises the next cycle. In any other state the write does nothing.
- R8: During execution `cmd_rdata` returns the command byte at `cmd_raddr` one cycle after the address is presented.
- R9: A byte with `rsp_last` ends execution. Status then reads 0x90 (data available, bit 4) while unread bytes remain, and the bytes come back on data-port reads in the order they were delivered.
- R10: Once the last response byte has been read, data available reads 0. A data-port read with nothing available returns 0xFF.
- R11: A status write with bit 6 set returns the engine to the ready state from any state, drops `exec_req` and discards the command and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address within the register window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| exec_req | output | 1 | Execution requested, held until the response ends or an abort |
| exec_len | output | CNT_W | Decoded command length |
| cmd_raddr | input | AW | Execution agent's command buffer read address |
| cmd_rdata | output | 8 | Command byte, one cycle after the address |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_last | input | 1 | Marks the final response byte (used with `rsp_valid`) |
| rsp_data | input | 8 | Response byte |

## Verification
A wrong state or byte counter shows up at the next status read. The ready, expect, available and error bits all come from the state and from the counter compared against the decoded length, so the status byte goes wrong and the burst count is off by the size of the error. A length decoder that weights the header bytes wrongly makes a legal command end early or late, or turns it into an error. That shows on the very byte where the length becomes known, or on the byte where completion should happen. Buffer addressing faults show on the first command byte the agent reads back, or on the first response byte the host drains.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [2:0] {
    ST_READY, ST_RECV, ST_FULL, ST_EXEC, ST_RESP, ST_FAULT
  } cfe_state_t;

  localparam int OFS_STS  = 'h18;
  localparam int OFS_FIFO = 'h24;
  localparam int HDR_LEN  = 10;
  localparam int LEN_MSB_IDX = 2;
  localparam int LEN_LSB_IDX = 5;
  localparam int BIT_READY = 6;
  localparam int BIT_GO    = 5;
endpackage

// File: rtl/cfe_buffer.sv
module cfe_buffer #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfe_len_decode.sv
module cfe_len_decode #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       din,
  output logic             known,
  output logic             bad,
  output logic [CNT_W-1:0] len
);
  import cfe_pkg::*;
  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc   <= '0;
      known <= 1'b0;
    end else if (push) begin
      if (idx >= CNT_W'(LEN_MSB_IDX) && idx <= CNT_W'(LEN_LSB_IDX))
        acc <= {acc[23:0], din};
      if (idx == CNT_W'(LEN_LSB_IDX))
        known <= 1'b1;
    end
  end

  assign bad = known && (acc < 32'(HDR_LEN) || acc > 32'(DEPTH));
  assign len = acc[CNT_W-1:0];
endmodule

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              exec_req,
  output logic [CNT_W-1:0]  exec_len,
  input  logic [AW-1:0]     cmd_raddr,
  output logic [7:0]        cmd_rdata,
  input  logic              rsp_valid,
  input  logic              rsp_last,
  input  logic [7:0]        rsp_data
);
  import cfe_pkg::*;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  cfe_state_t       st;
  logic [CNT_W-1:0] cnt, rsp_len, cmd_len;
  logic             len_known, len_bad;
  logic             sts_wr, ready_wr, go_wr, fifo_wr, fifo_rd, accept, rsp_we;
  logic             sts_ready, sts_expect, sts_avail, sts_err;
  logic [15:0]      burst;
  logic [7:0]       sts_byte, mem_q, reg_q;
  logic             use_mem_q;

  // host decode
  assign sts_wr   = host_wr && host_addr == ADDR_W'(OFS_STS);
  assign ready_wr = sts_wr && host_wdata[BIT_READY];
  assign go_wr    = sts_wr && host_wdata[BIT_GO];
  assign fifo_wr  = host_wr && host_addr == ADDR_W'(OFS_FIFO);
  assign fifo_rd  = host_rd && host_addr == ADDR_W'(OFS_FIFO);
  assign accept   = fifo_wr && !ready_wr &&
                    (st == ST_READY || (st == ST_RECV && !len_bad));
  assign rsp_we   = st == ST_EXEC && rsp_valid && !ready_wr && cnt < DEPTH_C;

  cfe_len_decode #(.DEPTH(DEPTH)) u_len (
    .clk(clk), .rst(rst), .clr(ready_wr), .push(accept),
    .idx(cnt), .din(host_wdata),
    .known(len_known), .bad(len_bad), .len(cmd_len)
  );

  cfe_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(accept || rsp_we), .waddr(cnt[AW-1:0]),
    .wdata(accept ? host_wdata : rsp_data),
    .raddr(st == ST_EXEC ? cmd_raddr : cnt[AW-1:0]),
    .rdata(mem_q)
  );

  // state machine and shared byte counter
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_READY;
      cnt     <= '0;
      rsp_len <= '0;
    end else if (ready_wr) begin
      st  <= ST_READY;
      cnt <= '0;
    end else begin
      case (st)
        ST_READY: if (accept) begin
          st  <= ST_RECV;
          cnt <= CNT_W'(1);
        end
        ST_RECV: begin
          if (len_bad) st <= ST_FAULT;
          else if (accept) begin
            cnt <= cnt + 1'b1;
            if (len_known && cnt + 1'b1 == cmd_len) st <= ST_FULL;
          end
        end
        ST_FULL: if (go_wr) begin
          st  <= ST_EXEC;
          cnt <= '0;
        end
        ST_EXEC: if (rsp_valid) begin
          if (rsp_last) begin
            st      <= ST_RESP;
            rsp_len <= (cnt < DEPTH_C) ? cnt + 1'b1 : cnt;
            cnt     <= '0;
          end else if (cnt < DEPTH_C) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RESP: if (fifo_rd && cnt < rsp_len) cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  // status and burst count
  assign sts_ready  = st == ST_READY;
  assign sts_expect = st == ST_RECV && !len_bad;
  assign sts_avail  = st == ST_RESP && cnt < rsp_len;
  assign sts_err    = st == ST_FAULT || (st == ST_RECV && len_bad);
  assign sts_byte   = {1'b1, sts_ready, 1'b0, sts_avail, sts_expect, sts_err, 2'b00};

  always_comb begin
    case (st)
      ST_READY: burst = 16'(DEPTH);
      ST_RECV:  burst = len_bad   ? 16'd0 :
                        len_known ? 16'(cmd_len - cnt) : 16'(DEPTH_C - cnt);
      ST_RESP:  burst = 16'(rsp_len - cnt);
      default:  burst = 16'd0;
    endcase
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem_q <= 1'b0;
      reg_q     <= 8'hFF;
    end else if (host_rd) begin
      use_mem_q <= fifo_rd && sts_avail;
      if (host_addr == ADDR_W'(OFS_STS))          reg_q <= sts_byte;
      else if (host_addr == ADDR_W'(OFS_STS + 1)) reg_q <= burst[7:0];
      else if (host_addr == ADDR_W'(OFS_STS + 2)) reg_q <= burst[15:8];
      else                                        reg_q <= 8'hFF;
    end
  end

  assign host_rdata = use_mem_q ? mem_q : reg_q;
  assign cmd_rdata  = mem_q;
  assign exec_req   = st == ST_EXEC;
  assign exec_len   = cmd_len;
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic              exec_req,
  input logic              full_st,
  input logic              sts_ready,
  input logic              sts_expect,
  input logic              sts_avail,
  input logic              sts_err,
  input logic [15:0]       burst
);
  logic abort_w, go_w;
  assign abort_w = host_wr && host_addr == ADDR_W'('h18) && host_wdata[6];
  assign go_w    = host_wr && host_addr == ADDR_W'('h18) && host_wdata[5];

  assert_expect_excl_R3: assert property (@(posedge clk) disable iff (rst)
    sts_expect |-> !sts_ready && !sts_avail && !sts_err);

  assert_err_no_expect_R5: assert property (@(posedge clk) disable iff (rst)
    sts_err |-> !sts_expect && burst == 16'd0);

  assert_go_starts_R7: assert property (@(posedge clk) disable iff (rst)
    (full_st && go_w && !abort_w) |=> exec_req);

  assert_abort_ready_R11: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> sts_ready && !exec_req);

  assert_avail_burst_R9: assert property (@(posedge clk) disable iff (rst)
    sts_avail |-> burst != 16'd0);

  assert_ready_full_burst_R2: assert property (@(posedge clk) disable iff (rst)
    sts_ready |-> burst != 16'd0);
endmodule

bind cmd_fifo_engine cfe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .exec_req(exec_req),
  .full_st(st == cfe_pkg::ST_FULL),
  .sts_ready(sts_ready), .sts_expect(sts_expect), .sts_avail(sts_avail),
  .sts_err(sts_err), .burst(burst)
);

// File: tb/sim_cmd_fifo_engine.sv
module sim_cmd_fifo_engine;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [7:0] A_STS = 8'h18, A_BLO = 8'h19, A_BHI = 8'h1A, A_FIFO = 8'h24;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata, cmd_rdata;
  logic exec_req;
  logic [CNT_W-1:0] exec_len;
  logic [AW-1:0] cmd_raddr = '0;
  logic rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] cmd [0:15];
  logic [7:0] d;

  always #2 clk = ~clk;

  cmd_fifo_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .exec_req(exec_req), .exec_len(exec_len), .cmd_raddr(cmd_raddr),
    .cmd_rdata(cmd_rdata), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic check_sts(input string req, input int exp_sts, input int exp_burst);
    logic [7:0] s, lo, hi;
    bus_rd(A_STS, s); bus_rd(A_BLO, lo); bus_rd(A_BHI, hi);
    chk({req, " status"}, s, exp_sts);
    chk({req, " burst"}, {hi, lo}, exp_burst);
  endtask

  task automatic fill_cmd(input int len_field, input int n);
    for (int i = 0; i < 16; i++) cmd[i] = 8'(8'h30 + i);
    cmd[0] = 8'h00; cmd[1] = 8'hC1;
    cmd[2] = 8'(len_field >> 24); cmd[3] = 8'(len_field >> 16);
    cmd[4] = 8'(len_field >> 8);  cmd[5] = 8'(len_field);
    if (n < 0) cmd[0] = 8'h00;
  endtask

  task automatic abort_eng();
    bus_wr(A_STS, 8'h40);
  endtask

  task automatic t_reset();
    check_sts("R1 reset", 8'hC0, DEPTH);
  endtask

  task automatic t_normal();
    fill_cmd(12, 12);
    bus_wr(A_FIFO, cmd[0]);
    check_sts("R3 first byte", 8'h88, DEPTH - 1);
    for (int i = 1; i < 3; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R2 length unknown", 8'h88, DEPTH - 3);
    for (int i = 3; i < 11; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R2 R3 one left", 8'h88, 1);
    bus_wr(A_FIFO, cmd[11]);
    check_sts("R3 complete", 8'h80, 0);
    bus_wr(A_FIFO, 8'hEE);
    check_sts("R6 write when full", 8'h80, 0);
    bus_wr(A_STS, 8'h20);
    chk("R7 exec_req after go", exec_req, 1);
    chk("R4 exec_len", exec_len, 12);
    for (int i = 0; i < 12; i++) begin
      cmd_raddr = AW'(i);
      @(negedge clk);
      chk("R8 command byte", cmd_rdata, cmd[i]);
    end
    bus_wr(A_FIFO, 8'h55);
    check_sts("R6 write during exec", 8'h80, 0);
    for (int i = 0; i < 3; i++) begin
      rsp_valid = 1'b1; rsp_data = 8'(8'hA0 + i); rsp_last = (i == 2);
      @(negedge clk);
    end
    rsp_valid = 1'b0; rsp_last = 1'b0;
    chk("R9 exec_req drops", exec_req, 0);
    check_sts("R9 response ready", 8'h90, 3);
    bus_rd(A_FIFO, d); chk("R9 byte 0", d, 8'hA0);
    check_sts("R2 two unread", 8'h90, 2);
    bus_rd(A_FIFO, d); chk("R9 byte 1", d, 8'hA1);
    bus_rd(A_FIFO, d); chk("R9 byte 2", d, 8'hA2);
    check_sts("R10 drained", 8'h80, 0);
    bus_rd(A_FIFO, d); chk("R10 empty read", d, 8'hFF);
    abort_eng();
    check_sts("R11 back to ready", 8'hC0, DEPTH);
  endtask

  task automatic t_short();
    fill_cmd(8, 6);
    for (int i = 0; i < 6; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R5 short length", 8'h84, 0);
    bus_wr(A_FIFO, 8'h11);
    check_sts("R5 write after error", 8'h84, 0);
    bus_wr(A_STS, 8'h20);
    chk("R7 go ignored in error", exec_req, 0);
    abort_eng();
    check_sts("R11 abort from error", 8'hC0, DEPTH);
  endtask

  task automatic t_long();
    fill_cmd(32'h0000_0100, 6);
    for (int i = 0; i < 6; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R4 R5 byte 4 weight", 8'h84, 0);
    abort_eng();
    fill_cmd(DEPTH + 1, 6);
    for (int i = 0; i < 6; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R5 just over depth", 8'h84, 0);
    abort_eng();
  endtask

  task automatic t_abort();
    bus_wr(A_STS, 8'h20);
    chk("R7 go ignored in ready", exec_req, 0);
    check_sts("R7 ready unchanged", 8'hC0, DEPTH);
    fill_cmd(10, 10);
    for (int i = 0; i < 10; i++) bus_wr(A_FIFO, cmd[i]);
    check_sts("R3 ten byte command", 8'h80, 0);
    bus_wr(A_STS, 8'h20);
    chk("R7 exec started", exec_req, 1);
    abort_eng();
    chk("R11 exec_req dropped", exec_req, 0);
    check_sts("R11 ready after exec abort", 8'hC0, DEPTH);
    fill_cmd(10, 10);
    for (int i = 0; i < 10; i++) bus_wr(A_FIFO, cmd[i]);
    bus_wr(A_STS, 8'h20);
    rsp_valid = 1'b1; rsp_data = 8'h77; rsp_last = 1'b0; @(negedge clk);
    rsp_data = 8'h78; rsp_last = 1'b1; @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
    check_sts("R9 two byte response", 8'h90, 2);
    abort_eng();
    check_sts("R11 discard response", 8'hC0, DEPTH);
    bus_rd(A_FIFO, d); chk("R10 read in ready", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_short();
    t_long();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule